// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block holds a bank of up to eight programmable outbound windows. Each window maps a range of the host-side bus address space onto a PCIe-side address and tags it with a transaction type: configuration, I/O or memory. Software programs every window through a simple 32-bit register port. At run time the block compares an incoming host address with all enabled windows in parallel, picks the winner and presents a hit flag, the window number, the type and the translated 64-bit address one clock later.

The size of a window is held as an inverted mask, the bitwise inverse of (size - 1). Its low 32 bits share the control word with the enable and type bits, and its upper 32 bits sit in a separate extension register. Because the enable and type bits occupy the bottom of the control word, the mask ignores control bits 11:0, so the smallest window is 4 KB. For configuration windows, software places the bus, device and function numbers in the upper half of the target low word. The translation ORs the in-window offset into the target, so those fields reach the output unchanged.

Top module: `ob_xlate`

## Requirements
- R1: While reset is active and after it ends, every window is disabled, every register reads zero, and the outputs are hit 0, window 0, type 0 and address 0.
- R2: Register map, with w being the window number: control at 0x0BA0+16w, host base at 0x0BA4+16w, target low at 0x0BA8+16w, target high at 0x0BAC+16w, and size-mask extension at 0xBAF0+4w. A written value reads back at that address in the following cycle. An address outside the map reads zero, and a write to it changes no register.
- R3: The host base register drops the two lowest bits of any written value, so it reads back with bits 1:0 equal to zero.
- R4: Control bit 0 enables the window. Bits 2:1 give the type: 0 = configuration, 1 = I/O, 2 = memory. The 64-bit mask is {extension, control[31:12], twelve zeros}, so control bits 11:3 have no effect on the mask.
- R5: Host address A hits window w only when w is enabled and (A AND mask) equals (base AND mask). A disabled window never hits, and an address one past the end of a window misses it.
- R6: On a hit, the translated address is {target high, target low} OR (A AND NOT mask), and the type and window number are those of the winning window.
- R7: For a configuration window no larger than 64 KB, the bus (target low 31:24), device (23:19) and function (18:16) fields appear unchanged in bits 31:16 of the translated address.
- R8: When several windows hit, the lowest-numbered window wins.
- R9: When no window hits, the outputs are hit 0, window 0, type 0 and address 0.
- R10: The result appears on the outputs at the first clock edge after the address is presented, with no combinational path from address to output. The lookup uses the window settings that were in force before that edge, so a register write at the same edge affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 16 | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |
| host_addr | input | HAW (32) | Host-side address to translate |
| xl_hit_o | output | 1 | A window matched |
| xl_win_o | output | IDX_W (3) | Index of the matching window |
| xl_type_o | output | 2 | Type of the matching window |
| xl_addr_o | output | 64 | Translated PCIe-side address |

## Verification
A register write and a lookup can fall in the same cycle. The bench provokes this by disabling a window at the same edge where an address inside that window is being translated. The result registered at that edge must still show a hit on the old settings, and the next lookup of the same address must miss. The bench also checks that changing the address between edges leaves the outputs untouched until the next edge, and it checks a lookup that lands in two overlapping windows, where the lower index must win.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

    localparam int CSR_AW    = 16;
    localparam int CSR_DW    = 32;
    localparam int PCIE_AW   = 64;
    localparam int MAX_WIN   = 8;
    localparam int PAGE_BITS = 12;

    localparam logic [CSR_AW-1:0] WIN_REG_BASE = 16'h0BA0;
    localparam logic [CSR_AW-1:0] SZX_REG_BASE = 16'hBAF0;
    localparam int WIN_STRIDE = 16;
    localparam int SZX_STRIDE = 4;

    localparam int OFS_CTRL  = 0;
    localparam int OFS_HBASE = 4;
    localparam int OFS_TLO   = 8;
    localparam int OFS_THI   = 12;

    typedef enum logic [1:0] {
        WT_CFG  = 2'd0,
        WT_IO   = 2'd1,
        WT_MEM  = 2'd2,
        WT_RSVD = 2'd3
    } win_type_e;

    typedef struct packed {
        logic [CSR_DW-1:0] ctrl;
        logic [CSR_DW-1:0] szx;
        logic [CSR_DW-1:0] hbase;
        logic [CSR_DW-1:0] tlo;
        logic [CSR_DW-1:0] thi;
    } win_cfg_t;

    function automatic logic [CSR_AW-1:0] reg_addr(
        input logic [CSR_AW-1:0] base,
        input int                stride,
        input int                idx,
        input int                ofs
    );
        return base + CSR_AW'(stride * idx + ofs);
    endfunction

    function automatic logic [PCIE_AW-1:0] win_mask(input win_cfg_t c);
        return {c.szx, c.ctrl[CSR_DW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
    import ob_xlate_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csr_we,
    input  logic [CSR_AW-1:0]       csr_addr,
    input  logic [CSR_DW-1:0]       csr_wdata,
    output logic [CSR_DW-1:0]       csr_rdata,
    output win_cfg_t [NWIN-1:0]     cfg_o
);

    typedef struct packed {
        win_cfg_t [NWIN-1:0] win;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d    = bank_q;
        csr_rdata = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (csr_addr == reg_addr(WIN_REG_BASE, WIN_STRIDE, w, OFS_CTRL)) begin
                csr_rdata = bank_q.win[w].ctrl;
                if (csr_we) bank_d.win[w].ctrl = csr_wdata;
            end
            if (csr_addr == reg_addr(WIN_REG_BASE, WIN_STRIDE, w, OFS_HBASE)) begin
                csr_rdata = bank_q.win[w].hbase;
                if (csr_we) bank_d.win[w].hbase = {csr_wdata[CSR_DW-1:2], 2'b00};
            end
            if (csr_addr == reg_addr(WIN_REG_BASE, WIN_STRIDE, w, OFS_TLO)) begin
                csr_rdata = bank_q.win[w].tlo;
                if (csr_we) bank_d.win[w].tlo = csr_wdata;
            end
            if (csr_addr == reg_addr(WIN_REG_BASE, WIN_STRIDE, w, OFS_THI)) begin
                csr_rdata = bank_q.win[w].thi;
                if (csr_we) bank_d.win[w].thi = csr_wdata;
            end
            if (csr_addr == reg_addr(SZX_REG_BASE, SZX_STRIDE, w, 0)) begin
                csr_rdata = bank_q.win[w].szx;
                if (csr_we) bank_d.win[w].szx = csr_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cfg_o = bank_q.win;

endmodule

// File: rtl/ob_xlate_match.sv
module ob_xlate_match
    import ob_xlate_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int HAW  = 32
) (
    input  win_cfg_t [NWIN-1:0] cfg_i,
    input  logic [HAW-1:0]      haddr_i,
    output logic [NWIN-1:0]     hit_o
);

    logic [PCIE_AW-1:0] haddr_x;
    assign haddr_x = PCIE_AW'(haddr_i);

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [PCIE_AW-1:0] mask_w;
        logic [PCIE_AW-1:0] base_w;
        assign mask_w   = win_mask(cfg_i[w]);
        assign base_w   = PCIE_AW'(cfg_i[w].hbase);
        assign hit_o[w] = cfg_i[w].ctrl[0] & ((haddr_x & mask_w) == (base_w & mask_w));
    end

endmodule

// File: rtl/ob_xlate_prio.sv
module ob_xlate_prio #(
    parameter int NWIN  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NWIN-1:0]  hit_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_i[w]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(w);
            end
        end
    end

endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
    import ob_xlate_pkg::*;
#(
    parameter int  NWIN  = MAX_WIN,
    parameter int  HAW   = 32,
    localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [CSR_AW-1:0]  csr_addr,
    input  logic [CSR_DW-1:0]  csr_wdata,
    output logic [CSR_DW-1:0]  csr_rdata,
    input  logic [HAW-1:0]     host_addr,
    output logic               xl_hit_o,
    output logic [IDX_W-1:0]   xl_win_o,
    output logic [1:0]         xl_type_o,
    output logic [PCIE_AW-1:0] xl_addr_o
);

    typedef struct packed {
        logic               hit;
        logic [IDX_W-1:0]   win;
        logic [1:0]         typ;
        logic [PCIE_AW-1:0] addr;
    } xl_out_t;

    win_cfg_t [NWIN-1:0] cfg;
    logic [NWIN-1:0]     hit_vec;
    logic                hit_any;
    logic [IDX_W-1:0]    hit_idx;
    win_cfg_t            sel_cfg;
    xl_out_t             out_d, out_q;

    ob_xlate_regs #(.NWIN(NWIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .cfg_o     (cfg)
    );

    ob_xlate_match #(.NWIN(NWIN), .HAW(HAW)) u_match (
        .cfg_i   (cfg),
        .haddr_i (host_addr),
        .hit_o   (hit_vec)
    );

    ob_xlate_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) u_prio (
        .hit_i (hit_vec),
        .any_o (hit_any),
        .idx_o (hit_idx)
    );

    always_comb begin
        out_d   = '0;
        sel_cfg = cfg[hit_idx];
        if (hit_any) begin
            out_d.hit  = 1'b1;
            out_d.win  = hit_idx;
            out_d.typ  = sel_cfg.ctrl[2:1];
            out_d.addr = {sel_cfg.thi, sel_cfg.tlo}
                       | (PCIE_AW'(host_addr) & ~win_mask(sel_cfg));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign xl_hit_o  = out_q.hit;
    assign xl_win_o  = out_q.win;
    assign xl_type_o = out_q.typ;
    assign xl_addr_o = out_q.addr;

endmodule

// File: rtl/ob_xlate_chk.sv
module ob_xlate_chk
    import ob_xlate_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int IDX_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_we,
    input logic [CSR_AW-1:0]  csr_addr,
    input logic [CSR_DW-1:0]  csr_wdata,
    input logic [CSR_DW-1:0]  csr_rdata,
    input logic [NWIN-1:0]    hit_vec,
    input logic               xl_hit_o,
    input logic [IDX_W-1:0]   xl_win_o,
    input logic [1:0]         xl_type_o,
    input logic [PCIE_AW-1:0] xl_addr_o
);

    localparam logic [CSR_AW-1:0] WIN_END = WIN_REG_BASE + CSR_AW'(NWIN * WIN_STRIDE);

    function automatic logic in_win_map(input logic [CSR_AW-1:0] a, input logic [3:0] ofs);
        return (a >= WIN_REG_BASE) && (a < WIN_END) && (a[3:0] == ofs);
    endfunction

    function automatic logic [NWIN-1:0] below(input logic [IDX_W-1:0] i);
        return (NWIN'(1) << i) - NWIN'(1);
    endfunction

    // R2
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && in_win_map(csr_addr, 4'h0))
        |=> (!$stable(csr_addr) || csr_rdata == $past(csr_wdata)));

    // R3
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_win_map(csr_addr, 4'h4) |-> csr_rdata[1:0] == 2'b00);

    // R8
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit_o |-> ((($past(hit_vec) >> xl_win_o) & NWIN'(1)) != '0)
                  && (($past(hit_vec) & below(xl_win_o)) == '0));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit_o |-> (xl_win_o == '0 && xl_type_o == 2'b00 && xl_addr_o == '0));

    // R10
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (xl_hit_o == $past(|hit_vec)));

endmodule

bind ob_xlate ob_xlate_chk #(.NWIN(NWIN), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .hit_vec   (hit_vec),
    .xl_hit_o  (xl_hit_o),
    .xl_win_o  (xl_win_o),
    .xl_type_o (xl_type_o),
    .xl_addr_o (xl_addr_o)
);

// File: tb/ob_xlate_tb.sv
module ob_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [15:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] host_addr = '0;
    logic        xl_hit_o;
    logic [2:0]  xl_win_o;
    logic [1:0]  xl_type_o;
    logic [63:0] xl_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ob_xlate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .host_addr (host_addr),
        .xl_hit_o  (xl_hit_o),
        .xl_win_o  (xl_win_o),
        .xl_type_o (xl_type_o),
        .xl_addr_o (xl_addr_o)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        hit;
        logic [2:0]  win;
        logic [1:0]  typ;
        logic [63:0] xa;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h4000_0ABC, 1'b1, 3'd0, 2'd0, 64'h0000_0000_032A_0ABC},
        '{32'h4000_FFFF, 1'b1, 3'd0, 2'd0, 64'h0000_0000_032A_FFFF},
        '{32'h4001_0000, 1'b0, 3'd0, 2'd0, 64'h0},
        '{32'h5000_0FFC, 1'b1, 3'd1, 2'd1, 64'h0000_0000_0001_0FFC},
        '{32'h5000_1000, 1'b0, 3'd0, 2'd0, 64'h0},
        '{32'h600A_BCDE, 1'b1, 3'd2, 2'd2, 64'h0000_0012_800A_BCDE},
        '{32'h6F00_0010, 1'b1, 3'd3, 2'd2, 64'h0000_00AB_0F00_0010},
        '{32'h7000_0000, 1'b0, 3'd0, 2'd0, 64'h0},
        '{32'h8000_0123, 1'b1, 3'd7, 2'd2, 64'h0000_0001_2000_0123},
        '{32'h0000_0000, 1'b0, 3'd0, 2'd0, 64'h0}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] outs();
        return {58'b0, xl_hit_o, xl_win_o, xl_type_o, xl_addr_o};
    endfunction

    function automatic logic [127:0] pack(input logic h, input logic [2:0] w,
                                          input logic [1:0] t, input logic [63:0] a);
        return {58'b0, h, w, t, a};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b0; csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic prog(input int w, input logic [31:0] ctrl, input logic [31:0] ext,
                        input logic [31:0] base, input logic [31:0] lo, input logic [31:0] hi);
        wr(16'h0BA0 + 16'(16 * w), ctrl);
        wr(16'h0BA4 + 16'(16 * w), base);
        wr(16'h0BA8 + 16'(16 * w), lo);
        wr(16'h0BAC + 16'(16 * w), hi);
        wr(16'hBAF0 + 16'(4 * w), ext);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        // R1: outputs and registers during and after reset
        repeat (2) @(negedge clk);
        chk("R1 outputs in reset", outs(), '0);
        rst_n = 1'b1;
        rd(16'h0BA0, r);
        chk("R1 ctrl after reset", 128'(r), 128'h0);
        chk("R1 outputs after reset", outs(), '0);

        // window setup (R4: ctrl bits 2:1 type, bit 0 enable)
        prog(0, 32'hFFFF_0001, 32'hFFFF_FFFF, 32'h4000_0000, 32'h032A_0000, 32'h0);
        prog(1, 32'hFFFF_F003, 32'hFFFF_FFFF, 32'h5000_0003, 32'h0001_0000, 32'h0);
        prog(2, 32'hFFF0_0005, 32'hFFFF_FFFF, 32'h6000_0000, 32'h8000_0000, 32'h12);
        prog(3, 32'hF000_0005, 32'hFFFF_FFFF, 32'h6000_0000, 32'h0000_0000, 32'hAB);
        prog(4, 32'hFFFF_F004, 32'hFFFF_FFFF, 32'h7000_0000, 32'h0000_0000, 32'h0);
        // R4: ctrl bits 11:3 set must not shrink the mask
        prog(7, 32'hFFFF_FFF5, 32'hFFFF_0000, 32'h8000_0000, 32'h2000_0000, 32'h1);

        // R2 readback and map
        rd(16'h0BB0, r);
        chk("R2 ctrl1 readback", 128'(r), 128'hFFFF_F003);
        rd(16'hBB0C, r);
        chk("R2 ext7 readback", 128'(r), 128'hFFFF_0000);
        rd(16'h0C1C, r);
        chk("R2 thi7 readback", 128'(r), 128'h1);
        // R3 base alignment
        rd(16'h0BB4, r);
        chk("R3 base1 low bits dropped", 128'(r), 128'h5000_0000);
        // R2 unmapped address
        wr(16'h0BA2, 32'hDEAD_BEEF);
        rd(16'h0BA2, r);
        chk("R2 unmapped reads zero", 128'(r), 128'h0);
        rd(16'h0BA0, r);
        chk("R2 unmapped write ignored", 128'(r), 128'hFFFF_0001);

        // table walk: R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_addr = VEC[i].a;
            @(negedge clk);
            chk($sformatf("table(R5,R6,R7,R8,R9) vec %0d", i), outs(),
                pack(VEC[i].hit, VEC[i].win, VEC[i].typ, VEC[i].xa));
        end

        // R10: no combinational path, result at next edge
        host_addr = 32'h8000_0123;
        #1 chk("R10 output holds before edge", outs(), pack(1'b0, 3'd0, 2'd0, 64'h0));
        @(negedge clk);
        chk("R10 output after one edge", outs(), pack(1'b1, 3'd7, 2'd2, 64'h1_2000_0123));

        // R10: disable window 1 at the same edge as a lookup into it
        host_addr = 32'h5000_0010;
        csr_we = 1'b1; csr_addr = 16'h0BB0; csr_wdata = 32'h0;
        @(negedge clk);
        csr_we = 1'b0;
        chk("R10 same-edge write uses old cfg", outs(), pack(1'b1, 3'd1, 2'd1, 64'h1_0010));
        @(negedge clk);
        chk("R5 disabled window misses", outs(), pack(1'b0, 3'd0, 2'd0, 64'h0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule